// File: doc/BRIEF.md
# Multi-Latency Issue Interlock Scoreboard

This block decides, cycle by cycle, whether the decoded instruction waiting in ID may leave for execution in an in-order, single-issue five-stage pipeline. The pipeline has execution units of different latency: a one-cycle integer unit, a two-cycle load path, a pipelined three-cycle FP adder, a pipelined seven-cycle multiplier and an unpipelined twenty-cycle divider. The block keeps a countdown for every register, showing how far away its pending result still is. It also keeps one busy countdown for the divider. Each operand is compared against the stage in which it is consumed. Most operands are consumed in EX. Store data is consumed in MEM, one stage later. Branch operands are consumed in ID, one stage earlier, because branches resolve there.

The instruction arrives on a valid/ready interface. `in_ready` is high when the presented fields raise no hazard. When `in_valid` is high and `in_ready` is low, the producer must hold every field stable. Issue happens on a clock edge at which both are high. `stall` repeats that hold condition for the rest of the pipeline. For each enabled source, `fwd_a` and `fwd_b` name the unit whose result bus supplies the operand. Branch delay slots need no special handling here: the block never squashes an instruction.

Top module: `scb_issue_ctl`

## Requirements
- R1: After reset, every register countdown and the divider countdown are zero. Any instruction presented then issues with no stall, and both forwarding selects read 0 (register file).
- R2: Operation codes are ALU=0, LOAD=1, STORE=2, FADD=3, MUL=4, DIV=5, BRANCH=6, NOP=7. At issue, a writing operation with `in_dst_en` high loads its destination countdown. The value loaded is ALU 1, LOAD 2, FADD 3, MUL 7 or DIV 20. Each countdown decreases by one per cycle and stops at zero.
- R3: A source read in EX is allowed when its countdown is at most 1. EX sources are `in_src_a` of every operation except BRANCH, and `in_src_b` of every operation except STORE and BRANCH. With g idle cycles after a producer of latency L, the consumer stalls max(0, L-1-g) cycles.
- R4: Store data (`in_src_b` of STORE) is read in MEM and is allowed when its countdown is at most 2. It stalls max(0, L-2-g) cycles.
- R5: Both sources of a BRANCH are read in ID and need a countdown of zero. A branch stalls max(0, L-g) cycles, so it stalls once right after an ALU producer.
- R6: The divider is unpipelined. A DIV stalls while the divider countdown (loaded with 20 at the previous DIV's issue) exceeds 1, so it stalls max(0, 19-g) cycles. MUL is pipelined: independent MULs issue back to back.
- R7: `in_ready` is low exactly when a hazard exists. `stall` is high only while `in_valid` is high and `in_ready` is low. Nothing is recorded unless `in_valid` and `in_ready` are both high.
- R8: At issue, an enabled source whose countdown is nonzero selects its producer's unit code: integer 1, load/memory 2, FP adder 3, multiplier 4, divider 5. Any other source selects 0.
- R9: STORE, BRANCH and NOP never claim their destination, even with `in_dst_en` high. A later reader of that register issues without stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present in ID |
| in_ready | output | 1 | No hazard; instruction may issue |
| in_op | input | 3 | Operation code (R2) |
| in_dst | input | AW (4) | Destination register |
| in_dst_en | input | 1 | Destination is written |
| in_src_a | input | AW (4) | First source register |
| in_src_a_en | input | 1 | First source is read |
| in_src_b | input | AW (4) | Second source register (store data for STORE) |
| in_src_b_en | input | 1 | Second source is read |
| stall | output | 1 | Instruction held in ID this cycle |
| fwd_a | output | 3 | Operand source for first source (R8) |
| fwd_b | output | 3 | Operand source for second source (R8) |

## Verification
The hardest situations to reach are the exact threshold cycles. Examples are the cycle where a countdown first drops to the consumer's limit, and the divider's last busy cycle twenty cycles after issue. Both are reached by fixed idle gaps rather than by chance. The bench issues every producer class and then inserts g idle cycles, sweeping g from zero to past the producer's latency. It then presents each consumer kind: EX reader, store data, store address and branch in both source slots. It counts the stall cycles and reads the forwarding select at issue. A dedicated sweep does the same for two divides, where no register dependence exists.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [2:0] {
    OP_ALU = 3'd0, OP_LOAD = 3'd1, OP_STORE = 3'd2, OP_FADD = 3'd3,
    OP_MUL = 3'd4, OP_DIV = 3'd5, OP_BRANCH = 3'd6, OP_NOP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    FU_RF = 3'd0, FU_INT = 3'd1, FU_MEM = 3'd2, FU_FADD = 3'd3,
    FU_MUL = 3'd4, FU_DIV = 3'd5
  } fu_e;

  // stage in which an operand is consumed
  typedef enum logic [1:0] {USE_ID = 2'd0, USE_EX = 2'd1, USE_MEM = 2'd2} use_e;
endpackage

// File: rtl/scb_reg_table.sv
module scb_reg_table #(
  parameter int AW  = 4,
  parameter int CW  = 5,
  parameter int NRD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_cnt,
  input  logic [2:0]    wr_fu,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [CW-1:0] rd_cnt  [NRD],
  output logic [2:0]    rd_fu   [NRD]
);
  localparam int NREG = 1 << AW;

  logic [CW-1:0] cnt_q [NREG];
  logic [2:0]    fu_q  [NREG];

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[r] <= '0;
        fu_q[r]  <= '0;
      end else if (wr_en && wr_addr == AW'(r)) begin
        cnt_q[r] <= wr_cnt;
        fu_q[r]  <= wr_fu;
      end else if (cnt_q[r] != '0) begin
        cnt_q[r] <= cnt_q[r] - CW'(1);
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_cnt[p] = cnt_q[rd_addr[p]];
    assign rd_fu[p]  = fu_q[rd_addr[p]];
  end
endmodule

// File: rtl/scb_busy_timer.sv
module scb_busy_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic [CW-1:0] remain
);
  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (start)          remain <= load;
    else if (remain != '0)   remain <= remain - CW'(1);
  end
endmodule

// File: rtl/scb_src_check.sv
module scb_src_check import scb_pkg::*; #(
  parameter int CW = 5
) (
  input  logic          en,
  input  use_e          use_stage,
  input  logic [CW-1:0] cnt,
  output logic          blocked
);
  always_comb begin
    blocked = 1'b0;
    if (en) begin
      unique case (use_stage)
        USE_ID:  blocked = (cnt != '0);
        USE_EX:  blocked = (cnt > CW'(1));
        USE_MEM: blocked = (cnt > CW'(2));
        default: blocked = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/scb_issue_ctl.sv
module scb_issue_ctl import scb_pkg::*; #(
  parameter int AW       = 4,
  parameter int LAT_ALU  = 1,
  parameter int LAT_LOAD = 2,
  parameter int LAT_FADD = 3,
  parameter int LAT_MUL  = 7,
  parameter int LAT_DIV  = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_op,
  input  logic [AW-1:0] in_dst,
  input  logic          in_dst_en,
  input  logic [AW-1:0] in_src_a,
  input  logic          in_src_a_en,
  input  logic [AW-1:0] in_src_b,
  input  logic          in_src_b_en,
  output logic          stall,
  output logic [2:0]    fwd_a,
  output logic [2:0]    fwd_b
);
  localparam int M1      = (LAT_ALU > LAT_LOAD) ? LAT_ALU : LAT_LOAD;
  localparam int M2      = (M1 > LAT_FADD) ? M1 : LAT_FADD;
  localparam int M3      = (M2 > LAT_MUL) ? M2 : LAT_MUL;
  localparam int LAT_MAX = (M3 > LAT_DIV) ? M3 : LAT_DIV;
  localparam int CW      = $clog2(LAT_MAX + 1);
  localparam int NSRC    = 2;

  op_e           op;
  logic          writes;
  logic [CW-1:0] new_cnt;
  fu_e           new_fu;
  logic          hazard, issue, div_block;
  logic [CW-1:0] div_rem;

  logic [AW-1:0] s_addr [NSRC];
  logic          s_en   [NSRC];
  use_e          s_use  [NSRC];
  logic [CW-1:0] s_cnt  [NSRC];
  logic [2:0]    s_fu   [NSRC];
  logic          s_blk  [NSRC];
  logic [2:0]    s_fwd  [NSRC];

  assign op = op_e'(in_op);

  // producer latency and result unit per operation
  always_comb begin
    writes  = 1'b1;
    new_cnt = '0;
    new_fu  = FU_RF;
    unique case (op)
      OP_ALU:  begin new_cnt = CW'(LAT_ALU);  new_fu = FU_INT;  end
      OP_LOAD: begin new_cnt = CW'(LAT_LOAD); new_fu = FU_MEM;  end
      OP_FADD: begin new_cnt = CW'(LAT_FADD); new_fu = FU_FADD; end
      OP_MUL:  begin new_cnt = CW'(LAT_MUL);  new_fu = FU_MUL;  end
      OP_DIV:  begin new_cnt = CW'(LAT_DIV);  new_fu = FU_DIV;  end
      default: writes = 1'b0;
    endcase
  end

  // where each operand is consumed
  assign s_addr[0] = in_src_a;
  assign s_addr[1] = in_src_b;
  assign s_en[0]   = in_src_a_en;
  assign s_en[1]   = in_src_b_en;
  assign s_use[0]  = (op == OP_BRANCH) ? USE_ID : USE_EX;
  assign s_use[1]  = (op == OP_BRANCH) ? USE_ID :
                     (op == OP_STORE)  ? USE_MEM : USE_EX;

  scb_reg_table #(.AW(AW), .CW(CW), .NRD(NSRC)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (issue && writes && in_dst_en),
    .wr_addr (in_dst),
    .wr_cnt  (new_cnt),
    .wr_fu   (new_fu),
    .rd_addr (s_addr),
    .rd_cnt  (s_cnt),
    .rd_fu   (s_fu)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    scb_src_check #(.CW(CW)) u_chk (
      .en        (s_en[s]),
      .use_stage (s_use[s]),
      .cnt       (s_cnt[s]),
      .blocked   (s_blk[s])
    );
    assign s_fwd[s] = (s_en[s] && s_cnt[s] != '0) ? s_fu[s] : FU_RF;
  end

  scb_busy_timer #(.CW(CW)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (issue && op == OP_DIV),
    .load   (CW'(LAT_DIV)),
    .remain (div_rem)
  );

  assign div_block = (op == OP_DIV) && (div_rem > CW'(1));
  assign hazard    = s_blk[0] || s_blk[1] || div_block;
  assign in_ready  = !hazard;
  assign issue     = in_valid && !hazard;
  assign stall     = in_valid && hazard;
  assign fwd_a     = s_fwd[0];
  assign fwd_b     = s_fwd[1];
endmodule

// File: rtl/scb_issue_ctl_chk.sv
module scb_issue_ctl_chk import scb_pkg::*; #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [2:0]    in_op,
  input logic [AW-1:0] in_dst,
  input logic          in_dst_en,
  input logic [AW-1:0] in_src_a,
  input logic          in_src_a_en,
  input logic [AW-1:0] in_src_b,
  input logic          in_src_b_en,
  input logic          stall,
  input logic [2:0]    fwd_a,
  input logic [2:0]    fwd_b
);
  logic fire;
  assign fire = in_valid && in_ready;

  p_div_unpipelined_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_DIV) |=> !(fire && in_op == OP_DIV));

  p_load_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_LOAD && in_dst_en) |=>
      !(fire && in_src_a_en && in_src_a == $past(in_dst)));

  p_branch_after_alu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_ALU && in_dst_en) |=>
      !(fire && in_op == OP_BRANCH && in_src_a_en && in_src_a == $past(in_dst)));

  p_store_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && in_op == OP_FADD && in_dst_en) |=>
      !(fire && in_op == OP_STORE && in_src_b_en && in_src_b == $past(in_dst)));

  p_idle_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> !stall);

  p_fwd_unused_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_src_a_en |-> fwd_a == 3'd0) and (!in_src_b_en |-> fwd_b == 3'd0));
endmodule

bind scb_issue_ctl scb_issue_ctl_chk #(.AW(AW)) u_assert (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_dst(in_dst), .in_dst_en(in_dst_en),
  .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
  .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
  .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
);

// File: tb/tb_scb_issue_ctl.sv
`timescale 1ns/1ps
module tb_scb_issue_ctl;
  localparam logic [2:0] ALU = 3'd0, LOAD = 3'd1, STORE = 3'd2, FADD = 3'd3,
                         MUL = 3'd4, DIV = 3'd5, BRANCH = 3'd6, NOP = 3'd7;

  logic       clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic       in_ready, stall;
  logic [2:0] in_op = ALU, fwd_a, fwd_b;
  logic [3:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic       in_dst_en = 1'b0, in_src_a_en = 1'b0, in_src_b_en = 1'b0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  scb_issue_ctl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_dst_en(in_dst_en),
    .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
    .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  function automatic int lat_of(logic [2:0] op);
    case (op)
      ALU: return 1;  LOAD: return 2;  FADD: return 3;
      MUL: return 7;  DIV: return 20;  default: return 0;
    endcase
  endfunction

  function automatic int unit_of(logic [2:0] op);
    case (op)
      ALU: return 1;  LOAD: return 2;  FADD: return 3;
      MUL: return 4;  DIV: return 5;   default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic present(logic [2:0] op, logic [3:0] d, logic de,
                         logic [3:0] a, logic ae, logic [3:0] b, logic be);
    @(negedge clk);
    in_op = op; in_dst = d; in_dst_en = de;
    in_src_a = a; in_src_a_en = ae; in_src_b = b; in_src_b_en = be;
    in_valid = 1'b1;
  endtask

  // wait until ready; returns stall cycles and forwarding selects at issue
  task automatic wait_issue(output int stalls, output int fa, output int fb);
    stalls = 0;
    #1;
    while (!in_ready && stalls < 60) begin
      check(stall == 1'b1, "R7 stall while held", int'(stall), 1);
      stalls++;
      @(negedge clk);
      #1;
    end
    fa = int'(fwd_a);
    fb = int'(fwd_b);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL R7 watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st, fa, fb;
    logic [2:0] cons_op [7];
    int         cons_slot [7];
    cons_op[0] = ALU;    cons_slot[0] = 0;
    cons_op[1] = ALU;    cons_slot[1] = 1;
    cons_op[2] = STORE;  cons_slot[2] = 0;
    cons_op[3] = STORE;  cons_slot[3] = 1;
    cons_op[4] = BRANCH; cons_slot[4] = 0;
    cons_op[5] = BRANCH; cons_slot[5] = 1;
    cons_op[6] = FADD;   cons_slot[6] = 0;

    repeat (3) @(negedge clk);
    #1;
    check(stall == 1'b0, "R7 no stall when idle in reset", int'(stall), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: clean table, strictest consumer (branch) on every register
    for (int r = 0; r < 16; r++) begin
      present(BRANCH, 4'd0, 1'b0, 4'(r), 1'b1, 4'(r), 1'b1);
      wait_issue(st, fa, fb);
      check(st == 0, "R1 no stall after reset", st, 0);
      check(fa == 0 && fb == 0, "R1 forward select after reset", fa + fb, 0);
    end
    idle(1);
    #1;
    check(stall == 1'b0, "R7 stall low while invalid", int'(stall), 0);

    // R2..R5, R8, R9: producer x consumer x idle gap sweep
    for (int p = 0; p < 8; p++) begin
      for (int c = 0; c < 7; c++) begin
        for (int g = 0; g <= lat_of(3'(p)) + 1; g++) begin
          int thr, rem, exp_st, exp_f, got_f;
          string tag;
          present(3'(p), 4'd3, 1'b1, 4'd11, 1'b1, 4'd12, 1'b1);
          wait_issue(st, fa, fb);
          idle(g);
          if (cons_slot[c] == 0)
            present(cons_op[c], 4'd13, 1'b1, 4'd3, 1'b1, 4'd9, 1'b1);
          else
            present(cons_op[c], 4'd13, 1'b1, 4'd9, 1'b1, 4'd3, 1'b1);
          wait_issue(st, fa, fb);
          thr = (cons_op[c] == BRANCH) ? 0 :
                (cons_op[c] == STORE && cons_slot[c] == 1) ? 2 : 1;
          rem = lat_of(3'(p)) - g;
          if (rem < 0) rem = 0;
          exp_st = rem - thr;
          if (exp_st < 0) exp_st = 0;
          exp_f = (rem - exp_st > 0) ? unit_of(3'(p)) : 0;
          got_f = (cons_slot[c] == 0) ? fa : fb;
          tag = (lat_of(3'(p)) == 0) ? "R9 dest ignored" :
                (thr == 0) ? "R5 branch in ID" :
                (thr == 2) ? "R4 store data in MEM" : "R3 EX operand";
          check(st == exp_st, $sformatf("%s stalls p%0d c%0d g%0d", tag, p, c, g),
                st, exp_st);
          check(got_f == exp_f, $sformatf("R8 forward select p%0d c%0d g%0d", p, c, g),
                got_f, exp_f);
          check(((cons_slot[c] == 0) ? fb : fa) == 0, "R8 clean source reads file",
                (cons_slot[c] == 0) ? fb : fa, 0);
          idle(22);
        end
      end
    end

    // R6: divider occupancy without register dependence
    for (int g = 0; g <= 21; g++) begin
      int exp_st;
      present(DIV, 4'd4, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
      wait_issue(st, fa, fb);
      idle(g);
      present(DIV, 4'd5, 1'b1, 4'd9, 1'b1, 4'd10, 1'b1);
      wait_issue(st, fa, fb);
      exp_st = (19 - g > 0) ? 19 - g : 0;
      check(st == exp_st, $sformatf("R6 divide after divide g%0d", g), st, exp_st);
      idle(22);
    end

    // R6: multiplier accepts back-to-back independent operations
    present(MUL, 4'd6, 1'b1, 4'd0, 1'b0, 4'd0, 1'b0);
    wait_issue(st, fa, fb);
    present(MUL, 4'd7, 1'b1, 4'd8, 1'b1, 4'd9, 1'b1);
    wait_issue(st, fa, fb);
    check(st == 0, "R6 pipelined multiply", st, 0);
    present(MUL, 4'd8, 1'b1, 4'd10, 1'b1, 4'd11, 1'b1);
    wait_issue(st, fa, fb);
    check(st == 0, "R6 pipelined multiply third", st, 0);
    idle(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule